// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block produces the logic-level PWM enables for a buck controller that can run with two, three or four phases. When it is enabled it first spends a short blanked window working out how many phases the board has fitted. It finds this out by looking at the upper two phase pins, which a board ties high when that phase is unused. It then hands out master-clock ticks to the active phases in turn, so each phase switches at the master rate divided by the phase count.

A duty-termination request per phase, from an external ramp comparator, ends the on-time of that phase. Unused upper phases are left undriven. While the window is running, and while the block is disabled, the two upper pins are not driven and a weak pull-down is applied to them. The sense inputs report the pin levels as a comparator sees them.

Top module: `pwm_phase_seq`

## Requirements
- R1: After reset, `phaseCount` is 4 and every `pwmOut` bit is low. `pwmOe` is 4'b0011, so phases 1 and 2 are driven and phases 3 and 4 are undriven, and `pullDownEn` is 2'b11.
- R2: In every cycle after a clock edge that samples `enable` low, every `pwmOut` bit is low, `pwmOe` is 4'b0011 and `pullDownEn` is 2'b11.
- R3: When `enable` is sampled high while the block is disabled, a detection window of exactly 4 cycles follows. It starts on the next cycle. During the window every `pwmOut` bit is low, `pwmOe` is 4'b0011 and `pullDownEn` is 2'b11.
- R4: The strap bits are sampled at the edge that ends the last cycle of the window. Bit 1 of `strapSense` is the phase 4 pin and bit 0 is the phase 3 pin. If bit 1 is low, `phaseCount` becomes 4, whatever bit 0 holds. The value 2'b10 gives 3, and 2'b11 gives 2.
- R5: `phaseCount` changes only at the end of a detection window. Changes to `strapSense` at any other time have no effect on it.
- R6: While running, `pullDownEn` is 2'b00. `pwmOe` is high exactly for phases 1 to `phaseCount`, and strapped phases keep `pwmOut` low.
- R7: The first running cycle is turn-on tick 0. Phase k+1 (index k) has its turn-on tick every `phaseCount` cycles, at offset k, and its `pwmOut` bit rises in the cycle after that tick.
- R8: A high `termReq[k]` sampled at an edge drives `pwmOut[k]` low in the next cycle. The exception is a request that arrives on that phase's own turn-on tick: the turn-on wins, and the request has no effect.
- R9: A phase that gets no termination request stays high through its next turn-on, which gives 100% duty. Several phases may be high at once.
- R10: Sampling `enable` low at any point during detection or running returns the block to the disabled state. The next enable runs a fresh detection window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Enable, combined with the supply-good condition |
| strapSense | input | 2 | Sensed pin level: bit 1 is the phase 4 pin, bit 0 is the phase 3 pin |
| termReq | input | 4 | Per-phase duty-termination request |
| pwmOut | output | 4 | Per-phase PWM level |
| pwmOe | output | 4 | Per-phase output drive enable; low means high impedance |
| pullDownEn | output | 2 | Weak pull-down on the phase 3 and phase 4 pins |
| phaseCount | output | 3 | Detected active phase count (2, 3 or 4) |

## Verification
A phase's turn-on tick and its own termination request can land in the same cycle. The sessions with the request held high on every cycle force this on every tick, and the random sessions hit it by chance. The check is that the phase still rises for exactly one cycle and then falls. Disabling can also coincide with a turn-on tick. Random mid-run drops of `enable` provoke this, and the check is that the outputs are low on the next cycle with no stray pulse.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  localparam int NumPhases = 4;
  localparam int StrapPins = 2;
  localparam int CountW    = $clog2(NumPhases + 1);
  localparam int SlotW     = $clog2(NumPhases);

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_DET = 2'd1,
    ST_RUN = 2'd2
  } seqState_t;

  typedef struct packed {
    logic                 clear;
    logic [NumPhases-1:0] turnOn;
  } seqStrobe_t;
endpackage

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
  import pwm_seq_pkg::*;
#(
  parameter int DetectCycles = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic [StrapPins-1:0]  strapSense,
  output seqStrobe_t            strobe,
  output logic [NumPhases-1:0]  activeMask,
  output logic [CountW-1:0]     phaseCount,
  output logic                  inRun
);
  localparam int DetW = $clog2(DetectCycles + 1);
  localparam logic [DetW-1:0] DetLast = DetW'(DetectCycles - 1);

  seqState_t          state;
  logic [DetW-1:0]    detCnt;
  logic [SlotW-1:0]   slot;
  logic [CountW-1:0]  decodedCount;

  // Upper straps: phase 4 pin decides, phase 3 pin only matters when phase 4 is strapped.
  always_comb begin
    if (!strapSense[1])     decodedCount = CountW'(NumPhases);
    else if (!strapSense[0]) decodedCount = CountW'(NumPhases - 1);
    else                    decodedCount = CountW'(NumPhases - 2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_OFF;
      detCnt     <= '0;
      slot       <= '0;
      phaseCount <= CountW'(NumPhases);
    end else if (!enable) begin
      state  <= ST_OFF;
      detCnt <= '0;
      slot   <= '0;
    end else begin
      case (state)
        ST_OFF: begin
          state  <= ST_DET;
          detCnt <= '0;
        end
        ST_DET: begin
          if (detCnt == DetLast) begin
            state      <= ST_RUN;
            slot       <= '0;
            phaseCount <= decodedCount;
          end else begin
            detCnt <= detCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (CountW'(slot) == phaseCount - 1'b1) slot <= '0;
          else                                     slot <= slot + 1'b1;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign inRun = (state == ST_RUN);

  always_comb begin
    strobe.clear  = !enable || !inRun;
    strobe.turnOn = '0;
    if (enable && inRun) strobe.turnOn[slot] = 1'b1;
  end

  generate
    for (genvar k = 0; k < NumPhases; k++) begin : g_mask
      assign activeMask[k] = (CountW'(k) < phaseCount);
    end
  endgenerate

  p_count_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phaseCount >= CountW'(NumPhases - 2)) && (phaseCount <= CountW'(NumPhases)));

  p_count_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && $past(inRun)) |-> $stable(phaseCount));

  p_single_turnon_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.turnOn));
endmodule

// File: rtl/pwm_seq_dp.sv
module pwm_seq_dp
  import pwm_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [NumPhases-1:0]  termReq,
  output logic [NumPhases-1:0]  pwmQ
);
  generate
    for (genvar k = 0; k < NumPhases; k++) begin : g_phase
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  pwmQ[k] <= 1'b0;
        else if (strobe.clear)      pwmQ[k] <= 1'b0;
        else if (strobe.turnOn[k])  pwmQ[k] <= 1'b1;
        else if (termReq[k])        pwmQ[k] <= 1'b0;
      end

      p_turnon_r7: assert property (@(posedge clk) disable iff (!rstN)
        strobe.turnOn[k] |=> pwmQ[k]);

      p_term_low_r8: assert property (@(posedge clk) disable iff (!rstN)
        (termReq[k] && !strobe.turnOn[k] && !strobe.clear) |=> !pwmQ[k]);
    end
  endgenerate

  p_blank_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (pwmQ == '0));
endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
  import pwm_seq_pkg::*;
#(
  parameter int DetectCycles = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [1:0]  strapSense,
  input  logic [3:0]  termReq,
  output logic [3:0]  pwmOut,
  output logic [3:0]  pwmOe,
  output logic [1:0]  pullDownEn,
  output logic [2:0]  phaseCount
);
  seqStrobe_t           strobe;
  logic [NumPhases-1:0] activeMask;
  logic                 inRun;

  pwm_seq_ctrl #(.DetectCycles(DetectCycles)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .strapSense (strapSense),
    .strobe     (strobe),
    .activeMask (activeMask),
    .phaseCount (phaseCount),
    .inRun      (inRun)
  );

  pwm_seq_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .termReq (termReq),
    .pwmQ    (pwmOut)
  );

  // Lower phases are always driven; upper phases are driven only when detected as active.
  assign pwmOe      = inRun ? activeMask : 4'b0011;
  assign pullDownEn = inRun ? 2'b00 : 2'b11;

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pwmOut == 4'b0000));

  p_tristate_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((pwmOut & ~pwmOe) == 4'b0000));
endmodule

// File: tb/pwm_phase_seq_tb.sv
module pwm_phase_seq_tb;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] strapSense = 2'b00;
  logic [3:0] termReq = 4'b0000;
  logic [3:0] pwmOut, pwmOe;
  logic [1:0] pullDownEn;
  logic [2:0] phaseCount;

  int checkCnt = 0;
  int failCnt = 0;
  bit firstCheck = 1'b1;

  // Reference state: 0 off, 1 detect, 2 run
  int         mState = 0;
  int         mDet = 0;
  int         mSlot = 0;
  int         mCount = 4;
  logic [3:0] mPwm = 4'b0000;

  pwm_phase_seq u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .strapSense(strapSense),
    .termReq(termReq), .pwmOut(pwmOut), .pwmOe(pwmOe),
    .pullDownEn(pullDownEn), .phaseCount(phaseCount)
  );

  always #(ClkPeriod/2) clk = ~clk;

  function automatic int decodeStrap(input logic [1:0] s);
    if (!s[1]) return 4;
    if (!s[0]) return 3;
    return 2;
  endfunction

  function automatic logic [3:0] maskOf(input int n);
    return 4'((1 << n) - 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: compare at negedge, drive new inputs, advance reference to the next edge.
  task automatic step(input logic en, input logic [1:0] st, input logic [3:0] tr);
    logic [3:0] turnOn;
    logic       clr;
    @(negedge clk);
    if (firstCheck) begin
      chk("R1 pwmOut", pwmOut, 0);
      chk("R1 pwmOe", pwmOe, 4'b0011);
      chk("R1 pullDownEn", pullDownEn, 2'b11);
      chk("R1 phaseCount", phaseCount, 4);
      firstCheck = 1'b0;
    end else begin
      if (mState == 2) begin
        chk("R7 R8 R9 pwmOut", pwmOut, mPwm);
        chk("R6 pwmOe", pwmOe, maskOf(mCount));
        chk("R6 pullDownEn", pullDownEn, 0);
      end else if (mState == 1) begin
        chk("R3 pwmOut", pwmOut, 0);
        chk("R3 pwmOe", pwmOe, 4'b0011);
        chk("R3 pullDownEn", pullDownEn, 2'b11);
      end else begin
        chk("R2 R10 pwmOut", pwmOut, 0);
        chk("R2 pwmOe", pwmOe, 4'b0011);
        chk("R2 pullDownEn", pullDownEn, 2'b11);
      end
      chk("R4 R5 phaseCount", phaseCount, mCount);
    end
    enable = en; strapSense = st; termReq = tr;
    clr = !en || (mState != 2);
    turnOn = (en && mState == 2) ? 4'(1 << mSlot) : 4'b0000;
    for (int k = 0; k < 4; k++) begin
      if (clr) mPwm[k] = 1'b0;
      else if (turnOn[k]) mPwm[k] = 1'b1;
      else if (tr[k]) mPwm[k] = 1'b0;
    end
    if (!en) begin
      mState = 0; mDet = 0; mSlot = 0;
    end else if (mState == 0) begin
      mState = 1; mDet = 0;
    end else if (mState == 1) begin
      if (mDet == 3) begin mState = 2; mSlot = 0; mCount = decodeStrap(st); end
      else mDet++;
    end else begin
      mSlot = (mSlot == mCount - 1) ? 0 : mSlot + 1;
    end
  endtask

  // termMode: 0 random, 1 always high, 2 never
  task automatic session(input logic [1:0] strap, input int runLen, input int termMode,
                         input bit wiggleStrap, input bit randomDrop);
    logic [3:0] tr;
    logic [1:0] st;
    repeat (3) step(1'b0, strap, 4'b0000);
    for (int i = 0; i < 5 + runLen; i++) begin
      st = (wiggleStrap && i > 5) ? 2'($urandom_range(0, 3)) : strap;
      if (termMode == 1) tr = 4'b1111;
      else if (termMode == 2) tr = 4'b0000;
      else tr = 4'($urandom) & 4'($urandom);
      if (randomDrop && i > 2 && $urandom_range(0, 30) == 0) begin
        step(1'b0, st, tr);
        step(1'b1, st, tr);
      end else begin
        step(1'b1, st, tr);
      end
    end
    step(1'b0, strap, 4'b0000);
  endtask

  initial begin
    repeat (WatchdogCycles) @(posedge clk);
    failCnt++; checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC0_0DE1));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Directed: each strap pattern, no termination (R9), then forced termination (R8)
    session(2'b00, 20, 2, 1'b0, 1'b0);
    session(2'b10, 20, 2, 1'b0, 1'b0);
    session(2'b11, 20, 2, 1'b0, 1'b0);
    session(2'b01, 20, 1, 1'b0, 1'b0);
    session(2'b10, 20, 1, 1'b0, 1'b0);
    // Strap changes during run are ignored (R5)
    session(2'b11, 40, 0, 1'b1, 1'b0);
    // Disable right at the end of detection (R10)
    repeat (2) step(1'b0, 2'b00, 4'b0000);
    for (int i = 0; i < 4; i++) step(1'b1, 2'b10, 4'b0000);
    step(1'b0, 2'b10, 4'b0000);
    // Constrained random sessions with mid-run drops
    for (int s = 0; s < 30; s++)
      session(2'($urandom_range(0, 3)), $urandom_range(10, 80), 0, 1'b1, 1'b1);
    step(1'b0, 2'b00, 4'b0000);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule